// File: doc/BRIEF.md
# Load/Store Lane Aligner

This block sits in the memory access path between a 64-bit load/store pipeline stage and a byte-addressed, doubleword-wide data memory port. For each request it receives an effective address, an access size code, a store/load flag, a signed/unsigned flag and the source data. It checks the natural alignment of the access. A misaligned request raises a one-cycle fault strobe, and that request writes nothing to memory.

For an aligned store, the block moves the low bytes of the source data into the memory lanes that the access covers. It also drives byte enables for exactly those lanes. For an aligned load, it records where the datum sits. When the memory returns the doubleword, it extracts the datum and sign-extends or zero-extends it to 64 bits, and it presents the result one cycle later. A byte-order input picks little-endian or big-endian lane numbering. Only one load may be outstanding at a time.

Top module: `lsu_lane_aligner`

## Requirements
- R1: The size code `req_size` is 0 for byte, 1 for half word, 2 for word and 3 for doubleword. An access is misaligned when it is a half word with address bit 0 set, a word with either of address bits 1:0 set, or a doubleword with any of address bits 2:0 set. A byte access is never misaligned.
- R2: For a valid misaligned request, `mem_be` is all zero in the request cycle. `fault` is high for exactly the following cycle. A trapped load produces no load result.
- R3: In little-endian mode (`big_endian`=0), an aligned access of s bytes at doubleword offset o (address bits 2:0) uses lanes o to o+s-1, with the datum's least significant byte in lane o. Lane k is `mem_be[k]` and data bits 8k+7:8k.
- R4: In big-endian mode, the same access uses lanes 8-o-s to 7-o, with the datum's least significant byte in lane 8-o-s.
- R5: A store writes only the low s bytes of `st_data`. Every lane of `mem_wdata` outside the enabled lanes is zero.
- R6: A signed load (`req_signed`=1) fills all bits above the datum with the datum's top bit.
- R7: An unsigned load fills all bits above the datum with zeros.
- R8: `ld_valid` pulses high with `ld_data` in the cycle after `rd_valid` when an aligned load is outstanding. A `rd_valid` with no load outstanding produces no pulse.
- R9: While reset is asserted and after it is released, `fault` and `ld_valid` are low.
- R10: `mem_be` and `mem_wdata` are zero for load requests and in cycles without a valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_signed | input | 1 | Load extension: 1 sign, 0 zero |
| req_size | input | 2 | Access size code (0 byte to 3 doubleword) |
| req_addr | input | AW (32) | Byte effective address |
| big_endian | input | 1 | Lane order: 1 big-endian, 0 little-endian |
| st_data | input | 64 | Store source register value |
| mem_be | output | 8 | Per-lane write enables |
| mem_wdata | output | 64 | Lane-placed write data |
| rd_valid | input | 1 | Memory read data valid |
| rd_data | input | 64 | Memory read doubleword |
| fault | output | 1 | One-cycle misalignment trap strobe |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Extended load result |

## Verification
Stores are tried at every size and in both byte orders, at offsets chosen so that little-endian and big-endian placement land in different lanes. A swapped lane formula or a wrong enable mask therefore shows up as a distinct byte pattern. Loads are read from one fixed doubleword whose bytes mix set and clear top bits, so signed and unsigned extension of the same lane give different results. Misaligned offsets for each size larger than a byte are checked against an unusual byte offset that must pass. A returned read with no load outstanding, and a returned read after a trapped load, separate the pending-load bookkeeping from the extraction path.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

endpackage

// File: rtl/lsu_misalign_detect.sv
module lsu_misalign_detect
    import lsu_align_pkg::*;
#(
    parameter int OFFW = 3
) (
    input  logic [OFFW-1:0] offset,
    input  acc_size_e       size,
    output logic            misaligned
);
    always_comb begin
        unique case (size)
            SZ_BYTE:  misaligned = 1'b0;
            SZ_HALF:  misaligned = offset[0];
            SZ_WORD:  misaligned = |offset[1:0];
            default:  misaligned = |offset[2:0];
        endcase
    end
endmodule

// File: rtl/lsu_lane_base.sv
module lsu_lane_base
    import lsu_align_pkg::*;
#(
    parameter int LANES = 8,
    localparam int OFFW = $clog2(LANES)
) (
    input  logic [OFFW-1:0] offset,
    input  acc_size_e       size,
    input  logic            big,
    output logic [OFFW-1:0] base
);
    logic [OFFW:0] nbytes;
    logic [OFFW:0] be_base;

    always_comb begin
        nbytes  = (OFFW+1)'(1) << size;
        be_base = (OFFW+1)'(LANES) - {1'b0, offset} - nbytes;
        base    = big ? be_base[OFFW-1:0] : offset;
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_align_pkg::*;
#(
    parameter int LANES = 8,
    localparam int OFFW = $clog2(LANES),
    localparam int DW   = LANES * 8
) (
    input  logic            en,
    input  logic [OFFW-1:0] base,
    input  acc_size_e       size,
    input  logic [DW-1:0]   sdata,
    output logic [LANES-1:0] be,
    output logic [DW-1:0]   wdata
);
    localparam logic [LANES:0] ONE = (LANES+1)'(1);

    logic [OFFW:0]    nbytes;
    logic [LANES:0]   ones_w;
    logic [DW-1:0]    sized;

    assign nbytes = (OFFW+1)'(1) << size;
    assign ones_w = (ONE << nbytes) - ONE;

    for (genvar i = 0; i < LANES; i++) begin : g_keep
        assign sized[8*i +: 8] = ((OFFW+1)'(i) < nbytes) ? sdata[8*i +: 8] : 8'h00;
    end

    always_comb begin
        if (en) begin
            be    = ones_w[LANES-1:0] << base;
            wdata = sized << {base, 3'b000};
        end else begin
            be    = '0;
            wdata = '0;
        end
    end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
    import lsu_align_pkg::*;
#(
    parameter int LANES = 8,
    localparam int OFFW = $clog2(LANES),
    localparam int DW   = LANES * 8
) (
    input  logic [DW-1:0]   rdata,
    input  logic [OFFW-1:0] base,
    input  acc_size_e       size,
    input  logic            sgn,
    output logic [DW-1:0]   value
);
    logic [DW-1:0] shifted;
    logic [OFFW:0] nbytes;
    logic          fill;

    always_comb begin
        shifted = rdata >> {base, 3'b000};
        nbytes  = (OFFW+1)'(1) << size;
        fill    = sgn & shifted[(8 << size) - 1];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_byte
        assign value[8*i +: 8] = ((OFFW+1)'(i) < nbytes) ? shifted[8*i +: 8] : {8{fill}};
    end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
    import lsu_align_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LANES = 8,
    localparam int OFFW = $clog2(LANES),
    localparam int DW   = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic             req_signed,
    input  logic [1:0]       req_size,
    input  logic [AW-1:0]    req_addr,
    input  logic             big_endian,
    input  logic [DW-1:0]    st_data,
    output logic [LANES-1:0] mem_be,
    output logic [DW-1:0]    mem_wdata,
    input  logic             rd_valid,
    input  logic [DW-1:0]    rd_data,
    output logic             fault,
    output logic             ld_valid,
    output logic [DW-1:0]    ld_data
);
    typedef struct packed {
        logic            fault;
        logic            pend;
        logic [OFFW-1:0] base;
        acc_size_e       size;
        logic            sgn;
        logic            ld_valid;
        logic [DW-1:0]   ld_data;
    } state_t;

    state_t state_d, state_q;

    acc_size_e       size_in;
    logic            mis;
    logic [OFFW-1:0] base_in;
    logic [DW-1:0]   ext;
    logic            store_en;
    logic            unused_addr_hi;

    assign size_in        = acc_size_e'(req_size);
    assign unused_addr_hi = ^req_addr[AW-1:OFFW];
    assign store_en       = req_valid & req_store & ~mis;

    lsu_misalign_detect #(.OFFW(OFFW)) u_mis (
        .offset     (req_addr[OFFW-1:0]),
        .size       (size_in),
        .misaligned (mis)
    );

    lsu_lane_base #(.LANES(LANES)) u_base (
        .offset (req_addr[OFFW-1:0]),
        .size   (size_in),
        .big    (big_endian),
        .base   (base_in)
    );

    lsu_store_lanes #(.LANES(LANES)) u_store (
        .en    (store_en),
        .base  (base_in),
        .size  (size_in),
        .sdata (st_data),
        .be    (mem_be),
        .wdata (mem_wdata)
    );

    lsu_load_extend #(.LANES(LANES)) u_load (
        .rdata (rd_data),
        .base  (state_q.base),
        .size  (state_q.size),
        .sgn   (state_q.sgn),
        .value (ext)
    );

    always_comb begin
        state_d          = state_q;
        state_d.fault    = req_valid & mis;
        state_d.ld_valid = 1'b0;
        if (rd_valid && state_q.pend) begin
            state_d.ld_valid = 1'b1;
            state_d.ld_data  = ext;
            state_d.pend     = 1'b0;
        end
        if (req_valid && !req_store && !mis) begin
            state_d.pend = 1'b1;
            state_d.base = base_in;
            state_d.size = size_in;
            state_d.sgn  = req_signed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign fault    = state_q.fault;
    assign ld_valid = state_q.ld_valid;
    assign ld_data  = state_q.ld_data;
endmodule

// File: rtl/lsu_lane_aligner_chk.sv
module lsu_lane_aligner_chk #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_store,
    input logic [1:0]       req_size,
    input logic [2:0]       addr_lo,
    input logic [LANES-1:0] mem_be,
    input logic             rd_valid,
    input logic             fault,
    input logic             ld_valid
);
    logic mis_c;
    logic rd_prev;

    always_comb begin
        case (req_size)
            2'd0:    mis_c = 1'b0;
            2'd1:    mis_c = addr_lo[0];
            2'd2:    mis_c = addr_lo[1] | addr_lo[0];
            default: mis_c = addr_lo != 3'b000;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= rd_valid;
    end

    assert_trap_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mis_c) |-> (mem_be == '0));

    assert_trap_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mis_c) |=> fault);

    assert_no_spurious_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && mis_c) |=> !fault);

    assert_be_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_be != '0) |-> ($countones(mem_be) == (32'd1 << req_size)));

    assert_load_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_store) |-> (mem_be == '0));

    assert_result_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> rd_prev);
endmodule

bind lsu_lane_aligner lsu_lane_aligner_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_store (req_store),
    .req_size  (req_size),
    .addr_lo   (req_addr[2:0]),
    .mem_be    (mem_be),
    .rd_valid  (rd_valid),
    .fault     (fault),
    .ld_valid  (ld_valid)
);

// File: tb/lsu_lane_aligner_test.sv
module lsu_lane_aligner_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic        req_signed = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = 32'h0;
    logic        big_endian = 1'b0;
    logic [63:0] st_data = 64'h0;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = 64'h0;
    logic        fault;
    logic        ld_valid;
    logic [63:0] ld_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    lsu_lane_aligner uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_signed(req_signed), .req_size(req_size), .req_addr(req_addr),
        .big_endian(big_endian), .st_data(st_data), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .fault(fault), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    localparam logic [63:0] SRC = 64'h1122334455667788;
    localparam logic [63:0] MEM = 64'h7F2E93C4356A1788;

    typedef struct packed {
        logic        st;
        logic        big;
        logic        sgn;
        logic [1:0]  sz;
        logic [2:0]  off;
        logic [7:0]  be;
        logic [63:0] wd;
        logic [63:0] ld;
        logic        flt;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VT [NV] = '{
        '{1'b1,1'b0,1'b0,2'd0,3'd3,8'h08,64'h0000000088000000,64'h0,1'b0},
        '{1'b1,1'b0,1'b0,2'd1,3'd6,8'hC0,64'h7788000000000000,64'h0,1'b0},
        '{1'b1,1'b0,1'b0,2'd2,3'd4,8'hF0,64'h5566778800000000,64'h0,1'b0},
        '{1'b1,1'b0,1'b0,2'd3,3'd0,8'hFF,64'h1122334455667788,64'h0,1'b0},
        '{1'b1,1'b1,1'b0,2'd0,3'd0,8'h80,64'h8800000000000000,64'h0,1'b0},
        '{1'b1,1'b1,1'b0,2'd1,3'd2,8'h30,64'h0000778800000000,64'h0,1'b0},
        '{1'b1,1'b1,1'b0,2'd2,3'd0,8'hF0,64'h5566778800000000,64'h0,1'b0},
        '{1'b1,1'b1,1'b0,2'd2,3'd4,8'h0F,64'h0000000055667788,64'h0,1'b0},
        '{1'b1,1'b0,1'b0,2'd1,3'd1,8'h00,64'h0,64'h0,1'b1},
        '{1'b1,1'b1,1'b0,2'd2,3'd2,8'h00,64'h0,64'h0,1'b1},
        '{1'b1,1'b0,1'b0,2'd3,3'd4,8'h00,64'h0,64'h0,1'b1},
        '{1'b1,1'b0,1'b0,2'd0,3'd5,8'h20,64'h0000880000000000,64'h0,1'b0},
        '{1'b0,1'b0,1'b1,2'd0,3'd0,8'h00,64'h0,64'hFFFFFFFFFFFFFF88,1'b0},
        '{1'b0,1'b0,1'b1,2'd0,3'd1,8'h00,64'h0,64'h0000000000000017,1'b0},
        '{1'b0,1'b0,1'b0,2'd0,3'd0,8'h00,64'h0,64'h0000000000000088,1'b0},
        '{1'b0,1'b0,1'b1,2'd1,3'd4,8'h00,64'h0,64'hFFFFFFFFFFFF93C4,1'b0},
        '{1'b0,1'b0,1'b0,2'd2,3'd4,8'h00,64'h0,64'h000000007F2E93C4,1'b0},
        '{1'b0,1'b0,1'b1,2'd2,3'd0,8'h00,64'h0,64'h00000000356A1788,1'b0},
        '{1'b0,1'b1,1'b1,2'd0,3'd0,8'h00,64'h0,64'h000000000000007F,1'b0},
        '{1'b0,1'b1,1'b1,2'd0,3'd3,8'h00,64'h0,64'hFFFFFFFFFFFFFFC4,1'b0},
        '{1'b0,1'b1,1'b1,2'd1,3'd6,8'h00,64'h0,64'h0000000000001788,1'b0},
        '{1'b0,1'b1,1'b1,2'd1,3'd2,8'h00,64'h0,64'hFFFFFFFFFFFF93C4,1'b0},
        '{1'b0,1'b0,1'b1,2'd3,3'd0,8'h00,64'h0,64'h7F2E93C4356A1788,1'b0},
        '{1'b0,1'b0,1'b1,2'd1,3'd3,8'h00,64'h0,64'h0,1'b1},
        '{1'b0,1'b0,1'b0,2'd1,3'd4,8'h00,64'h0,64'h00000000000093C4,1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R9 fault in reset", 64'(fault), 64'h0);
        chk("R9 ld_valid in reset", 64'(ld_valid), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R9 fault after reset", 64'(fault), 64'h0);
        chk("R9 ld_valid after reset", 64'(ld_valid), 64'h0);
        chk("R10 idle be", 64'(mem_be), 64'h0);

        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            req_valid  = 1'b1;
            req_store  = VT[n].st;
            big_endian = VT[n].big;
            req_signed = VT[n].sgn;
            req_size   = VT[n].sz;
            req_addr   = 32'h0000_1240 | 32'(VT[n].off);
            st_data    = SRC;
            #1;
            if (VT[n].flt) begin
                chk("R2 trapped be", 64'(mem_be), 64'(VT[n].be));
            end else if (VT[n].st) begin
                chk(VT[n].big ? "R4 store be" : "R3 store be", 64'(mem_be), 64'(VT[n].be));
                chk("R5 store wdata", mem_wdata, VT[n].wd);
            end else begin
                chk("R10 load be", 64'(mem_be), 64'h0);
                chk("R10 load wdata", mem_wdata, 64'h0);
            end
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk("R1 fault strobe", 64'(fault), 64'(VT[n].flt));
            if (!VT[n].st && !VT[n].flt) begin
                rd_valid = 1'b1;
                rd_data  = MEM;
                @(negedge clk);
                rd_valid = 1'b0;
                #1;
                chk("R8 ld_valid", 64'(ld_valid), 64'h1);
                chk(VT[n].sgn ? (VT[n].big ? "R6 R4 load" : "R6 R3 load")
                              : (VT[n].big ? "R7 R4 load" : "R7 R3 load"),
                    ld_data, VT[n].ld);
                @(negedge clk);
                #1;
                chk("R8 ld_valid pulse end", 64'(ld_valid), 64'h0);
            end else begin
                @(negedge clk);
                #1;
                chk("R2 fault one cycle", 64'(fault), 64'h0);
            end
        end

        // R2: a trapped load leaves nothing outstanding
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b0; req_size = 2'd2;
        req_addr = 32'h0000_1242; big_endian = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        rd_valid = 1'b1; rd_data = MEM;
        @(negedge clk);
        rd_valid = 1'b0;
        #1;
        chk("R2 trapped load result", 64'(ld_valid), 64'h0);

        // R8: read return with nothing outstanding
        @(negedge clk);
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        #1;
        chk("R8 stray read", 64'(ld_valid), 64'h0);

        // R10: store fields present but request not valid
        @(negedge clk);
        req_valid = 1'b0; req_store = 1'b1; req_size = 2'd3; req_addr = 32'h0000_1240;
        #1;
        chk("R10 invalid store be", 64'(mem_be), 64'h0);
        chk("R10 invalid store wdata", mem_wdata, 64'h0);
        @(negedge clk);
        #1;
        chk("R2 no fault when idle", 64'(fault), 64'h0);

        summary();
        $finish;
    end
endmodule